// File: doc/BRIEF.md
# Circular Return-Address Stack

This block keeps the return addresses of a small processor in an eight-slot ring of 13-bit words. A push strobe, raised when a subroutine call executes or when an interrupt vectors, stores the address on `push_data_i`. A pop strobe, raised on any of the return flavours, brings the most recent entry out on `tos_o`. Instruction decode and the choice of the next program counter sit outside the block.

The pointer is private and software cannot reach it. The block reports no overflow and no underflow. A push past eight entries overwrites the oldest slot. A pop past empty walks backwards around the ring and presents whatever that slot holds. Reset returns the pointer to slot zero and clears the output register, but leaves the stored words as they were.

Top module: `ret_ring_stack`

## Requirements
- R1: While `rst` is high at a rising edge, the pointer goes to slot 0 and `tos_o` reads 0 after that edge.
- R2: A push writes `push_data_i` into the slot the pointer selects, then moves the pointer forward one slot, modulo 8 (slot 7 goes to slot 0).
- R3: A pop without a push first moves the pointer back one slot, modulo 8 (slot 0 goes to slot 7). `tos_o` then shows that slot's word from the rising edge on which the pop is sampled.
- R4: Words come back in last-in first-out order across interleaved pushes and pops.
- R5: The ninth push after reset overwrites the word from the first push. After nine pushes A0..A8, nine pops return A8, A7, ..., A1 and then A8 again.
- R6: A pop at slot 0 wraps to slot 7 and returns slot 7's current word. No error indication exists.
- R7: `tos_o` holds its value on every cycle without a pop, including cycles with a push.
- R8: When push and pop are both high, only the push takes effect and `tos_o` is unchanged.
- R9: Reset leaves the stored words intact. After eight pushes C0..C7 and a reset, a pop returns C7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| push_i | input | 1 | Push strobe (call or interrupt vector) |
| pop_i | input | 1 | Pop strobe (any return) |
| push_data_i | input | 13 | Return address to store |
| tos_o | output | 13 | Registered word of the last pop |

## Verification
`tos_o` is the only visible result. It changes on the same rising edge that samples a pop, and it keeps its value after a push, an idle cycle or a push and pop together. The bench drives each operation at a falling edge and compares `tos_o` at the next falling edge against a reference ring that the bench maintains. Every check therefore lands one edge after its stimulus, with no race at the active edge. Pointer movement is proven through the words that later pops return: wrap on overflow, wrap on underflow, and contents that survive a reset.

// File: rtl/rstk_pkg.sv
package rstk_pkg;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_PUSH = 2'd1,
    OP_POP  = 2'd2
  } op_e;

  // push wins over a simultaneous pop (R8)
  function automatic op_e decode_op(input logic push, input logic pop);
    if (push)     return OP_PUSH;
    else if (pop) return OP_POP;
    else          return OP_IDLE;
  endfunction

endpackage

// File: rtl/rstk_ptr.sv
module rstk_ptr
  import rstk_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  op_e           op,
  output logic [AW-1:0] wr_idx,
  output logic [AW-1:0] rd_idx
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] ptr;
  logic [AW-1:0] ptr_inc;
  logic [AW-1:0] ptr_dec;

  always_comb begin
    ptr_inc = (ptr == LAST) ? '0 : ptr + 1'b1;
    ptr_dec = (ptr == '0) ? LAST : ptr - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else begin
      unique case (op)
        OP_PUSH: ptr <= ptr_inc;
        OP_POP:  ptr <= ptr_dec;
        default: ptr <= ptr;
      endcase
    end
  end

  assign wr_idx = ptr;
  assign rd_idx = ptr_dec;

  // R1: pointer back at slot 0 after reset
  p_reset_zero_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> ptr == '0);

  // R2: push advances modulo depth
  p_push_adv_r2: assert property (@(posedge clk) disable iff (rst)
    op == OP_PUSH |=> int'(ptr) == (int'($past(ptr)) + 1) % DEPTH);

  // R3, R6: pop steps back modulo depth
  p_pop_back_r3: assert property (@(posedge clk) disable iff (rst)
    op == OP_POP |=> int'(ptr) == (int'($past(ptr)) + DEPTH - 1) % DEPTH);

  // R7: idle keeps the pointer
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
    op == OP_IDLE |=> $stable(ptr));

endmodule

// File: rtl/rstk_mem.sv
module rstk_mem #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 13,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] ram [DEPTH];

  // write port: contents survive reset (R9)
  always_ff @(posedge clk) begin
    if (we) ram[waddr] <= wdata;
  end

  // registered read with output-register reset
  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= ram[raddr];
  end

  // R7: output register only moves on a read
  p_read_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !re |=> $stable(rdata));

  // R8: decode never asks for both ports in one cycle
  p_port_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(we && re));

endmodule

// File: rtl/ret_ring_stack.sv
module ret_ring_stack
  import rstk_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int WIDTH = 13,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [WIDTH-1:0] push_data_i,
  output logic [WIDTH-1:0] tos_o
);

  op_e           op;
  logic [AW-1:0] wr_idx;
  logic [AW-1:0] rd_idx;
  logic          we;
  logic          re;

  always_comb begin
    op = decode_op(push_i, pop_i);
    we = (op == OP_PUSH);
    re = (op == OP_POP);
  end

  rstk_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk    (clk),
    .rst    (rst),
    .op     (op),
    .wr_idx (wr_idx),
    .rd_idx (rd_idx)
  );

  rstk_mem #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_mem (
    .clk   (clk),
    .rst   (rst),
    .we    (we),
    .waddr (wr_idx),
    .wdata (push_data_i),
    .re    (re),
    .raddr (rd_idx),
    .rdata (tos_o)
  );

  // R1: output cleared after reset
  p_reset_out_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> tos_o == '0);

  // R8: push with pop leaves the output alone
  p_pushpop_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (push_i && pop_i) |=> $stable(tos_o));

  // R7: a push alone leaves the output alone
  p_push_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (push_i && !pop_i) |=> $stable(tos_o));

endmodule

// File: tb/sim_ret_ring_stack.sv
`timescale 1ns/1ps
module sim_ret_ring_stack;

  localparam int D = 8;
  localparam int W = 13;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         push_i = 1'b0;
  logic         pop_i = 1'b0;
  logic [W-1:0] push_data_i = '0;
  logic [W-1:0] tos_o;

  always #2 clk = ~clk;

  ret_ring_stack #(.DEPTH(D), .WIDTH(W)) u0 (
    .clk(clk), .rst(rst), .push_i(push_i), .pop_i(pop_i),
    .push_data_i(push_data_i), .tos_o(tos_o)
  );

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;

  logic [W-1:0] mm [D];
  int           mp = 0;
  logic [W-1:0] mt = '0;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000 && !done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: actual cycles %0d expected <= 200000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  function automatic int nxt(int p); return (p + 1) % D; endfunction
  function automatic int prv(int p); return (p + D - 1) % D; endfunction

  task automatic check(string tag);
    n_run++;
    if (tos_o !== mt) begin
      n_fail++;
      $display("FAIL %s: tos_o actual %h expected %h", tag, tos_o, mt);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; push_i = 0; pop_i = 0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    mp = 0; mt = '0;
    check("R1");
  endtask

  task automatic step(bit pu, bit po, logic [W-1:0] d, string tag);
    push_i = pu; pop_i = po; push_data_i = d;
    if (pu) begin
      mm[mp] = d;
      mp = nxt(mp);
    end else if (po) begin
      mp = prv(mp);
      mt = mm[mp];
    end
    @(negedge clk);
    push_i = 0; pop_i = 0;
    check(tag);
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    @(negedge clk);
    do_reset();

    // fill every slot: pushes leave output at 0
    for (int i = 0; i < D; i++) step(1, 0, W'(13'h100 + i), "R2/R7 push hold");
    step(0, 1, '0, "R3 pop top");
    step(0, 1, '0, "R4 second pop");
    step(1, 0, 13'h0abc, "R7 push");
    step(1, 0, 13'h1def, "R7 push");
    step(0, 0, '0, "R7 idle");
    step(0, 1, '0, "R4 lifo");
    step(0, 1, '0, "R4 lifo");

    // contents survive reset; pop from slot 0 wraps to slot 7
    for (int i = 0; i < D; i++) step(1, 0, W'(13'h0c00 + i), "R2 fill");
    do_reset();
    step(0, 1, '0, "R9/R6 wrap after reset");
    step(0, 1, '0, "R6 underflow chain");

    // ninth push overwrites first
    do_reset();
    for (int i = 0; i < D + 1; i++) step(1, 0, W'(13'h0a00 + i), "R5 push");
    for (int i = 0; i < D + 1; i++) step(0, 1, '0, "R5 overflow pop");

    // push with pop: push only
    step(0, 1, '0, "R3 pop");
    step(1, 1, 13'h1234, "R8 push+pop hold");
    step(0, 1, '0, "R8 pushed word returns");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = int'($urandom % 8);
      case (r)
        0, 1, 2: step(1, 0, W'($urandom), "R2/R7 rand push");
        3, 4, 5: step(0, 1, '0, "R3/R4 rand pop");
        6:       step(1, 1, W'($urandom), "R8 rand both");
        default: step(0, 0, '0, "R7 rand idle");
      endcase
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule